// File: doc/BRIEF.md
# Interrupt Security Target Controller

This block sits in front of a processor's interrupt entry logic on a chip that runs code in two security domains. Each of `N` interrupt lines has a target bit, and the secure domain programs these bits to assign the line to either the secure or the non-secure domain. Every cycle the block takes the raw request lines and their 3-bit priorities. It applies the rules of each domain: non-secure lines can be pushed into the less urgent half of the priority range, and one mask bit can hold back all non-secure lines. It then selects a single winner.

The selection is registered. One clock edge after the inputs are sampled, the block presents a valid flag, the winning line number, the domain that line targets, and a cross-state flag. The cross-state flag tells the core that it must save and clear its secure state before taking the interrupt. The outputs are plain level status with no back-pressure. The winner is recomputed on every edge from the current requests, so the block never holds a stale request and needs no ready signal.

Top module: `irq_sec_route`

## Requirements
- R1: After reset every line targets the secure domain, the deprioritise bit is clear, the non-secure mask is clear, and `sel_valid` is low. A secure read of every register returns zero.
- R2: A secure write to address 0 loads `reg_wdata[i]` into the target bit of line i, where 1 means non-secure. A secure read of address 0 returns those bits.
- R3: Writes from the non-secure domain to address 0 (targets) or to address 1 (bit 0 = deprioritise) have no effect. Non-secure reads of those two addresses return zero.
- R4: A line of either domain can win whether `cur_secure` is high (secure code running) or low.
- R5: A lower priority value is more urgent (`irq_prio[3i+2:3i]` is the priority of line i). When effective priorities are equal, the lower line number wins.
- R6: When the deprioritise bit is set, a non-secure line with priority p competes at (p >> 1) + 4. Secure lines keep their own value.
- R7: While the non-secure mask (address 2, bit 0) is set, no non-secure line can win, and secure lines still compete. Either domain can write and read the mask.
- R8: `sel_valid` is high exactly when at least one request was eligible at the previous clock edge. The outputs change only at a clock edge, one cycle after the inputs are sampled.
- R9: `sel_cross` is high when the winner's domain differs from the execution state (`cur_secure`) sampled with it.
- R10: `sel_nonsec` equals the target bit of the winning line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | N | Raw request per line |
| irq_prio | input | 3*N | Priority per line, line i at bits 3i+2:3i |
| cur_secure | input | 1 | 1 while the core runs secure code |
| reg_wr | input | 1 | Register write strobe |
| reg_secure | input | 1 | Domain of the register access, 1 = secure |
| reg_addr | input | 2 | 0 targets, 1 control, 2 non-secure mask |
| reg_wdata | input | N | Write data |
| reg_rdata | output | N | Read data for `reg_addr`, combinational |
| sel_valid | output | 1 | A winner is present |
| sel_id | output | max(1,clog2 N) | Winning line number |
| sel_nonsec | output | 1 | Winner targets the non-secure domain |
| sel_cross | output | 1 | Taking the winner needs a state change |

## Verification
The bench builds the block with `N = 6`. This makes the line-number field 3 bits wide with two codes that never occur, so every line, including the top line 5, can be made to win or lose. The priority width is the fixed 3 bits, which puts the full remap range 4..7 and collisions between remapped and native priorities within reach. Vectors cover ties at the lowest and highest line numbers, masking with mixed targets, and all four combinations of winner domain and execution state.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int PRIO_W = 3;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_TARGET = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] A_NSMASK = 2'd2;
endpackage

// File: rtl/isr_regs.sv
module isr_regs
  import isr_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sec,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      rdata,
  output logic [N-1:0]      target_q,
  output logic              deprio_q,
  output logic              ns_mask_q
);
  // Targets and deprioritise are writable only by secure accesses;
  // the mask is shared by both domains.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q  <= '0;
      deprio_q  <= 1'b0;
      ns_mask_q <= 1'b0;
    end else if (wr) begin
      case (addr)
        A_TARGET: if (sec) target_q <= wdata;
        A_CTRL:   if (sec) deprio_q <= wdata[0];
        A_NSMASK: ns_mask_q <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_TARGET: if (sec) rdata = target_q;
      A_CTRL:   if (sec) rdata[0] = deprio_q;
      A_NSMASK: rdata[0] = ns_mask_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/isr_rank.sv
module isr_rank
  import isr_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0]        req,
  input  logic [N*PRIO_W-1:0] prio,
  input  logic [N-1:0]        target,
  input  logic                deprio,
  input  logic                ns_mask,
  output logic [N-1:0]        elig,
  output logic [N*PRIO_W-1:0] eff
);
  localparam logic [PRIO_W-1:0] HALF = PRIO_W'(1 << (PRIO_W - 1));

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [PRIO_W-1:0] p;
    assign p = prio[g*PRIO_W +: PRIO_W];
    assign eff[g*PRIO_W +: PRIO_W] = (target[g] && deprio) ? ((p >> 1) + HALF) : p;
    assign elig[g] = req[g] && !(target[g] && ns_mask);
  end
endmodule

// File: rtl/isr_pick.sv
module isr_pick
  import isr_pkg::*;
#(
  parameter int N = 8,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]        elig,
  input  logic [N*PRIO_W-1:0] eff,
  output logic                found,
  output logic [IDW-1:0]      id
);
  logic [PRIO_W-1:0] best;

  // Linear scan; strict compare keeps the lower index on a tie.
  always_comb begin
    found = 1'b0;
    id    = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || eff[i*PRIO_W +: PRIO_W] < best)) begin
        found = 1'b1;
        id    = IDW'(i);
        best  = eff[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irq_sec_route.sv
module irq_sec_route
  import isr_pkg::*;
#(
  parameter int N = 8,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        irq_req,
  input  logic [N*PRIO_W-1:0] irq_prio,
  input  logic                cur_secure,
  input  logic                reg_wr,
  input  logic                reg_secure,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [N-1:0]        reg_wdata,
  output logic [N-1:0]        reg_rdata,
  output logic                sel_valid,
  output logic [IDW-1:0]      sel_id,
  output logic                sel_nonsec,
  output logic                sel_cross
);
  logic [N-1:0]        target_q;
  logic                deprio_q;
  logic                ns_mask_q;
  logic [N-1:0]        elig;
  logic [N*PRIO_W-1:0] eff;
  logic                found;
  logic [IDW-1:0]      win;

  isr_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sec(reg_secure),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .target_q(target_q), .deprio_q(deprio_q), .ns_mask_q(ns_mask_q)
  );

  isr_rank #(.N(N)) u_rank (
    .req(irq_req), .prio(irq_prio), .target(target_q),
    .deprio(deprio_q), .ns_mask(ns_mask_q), .elig(elig), .eff(eff)
  );

  isr_pick #(.N(N)) u_pick (
    .elig(elig), .eff(eff), .found(found), .id(win)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_valid  <= 1'b0;
      sel_id     <= '0;
      sel_nonsec <= 1'b0;
      sel_cross  <= 1'b0;
    end else begin
      sel_valid  <= found;
      sel_id     <= win;
      sel_nonsec <= found && target_q[win];
      sel_cross  <= found && (target_q[win] == cur_secure);
    end
  end
endmodule

// File: rtl/isr_chk.sv
module isr_chk
  import isr_pkg::*;
#(
  parameter int N = 8,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N-1:0]      irq_req,
  input logic              cur_secure,
  input logic              reg_wr,
  input logic              reg_secure,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              sel_valid,
  input logic [IDW-1:0]    sel_id,
  input logic              sel_nonsec,
  input logic              sel_cross,
  input logic [N-1:0]      target_q,
  input logic              ns_mask_q
);
  logic [N-1:0] req_d;
  logic         cur_d;
  logic         mask_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d  <= '0;
      cur_d  <= 1'b1;
      mask_d <= 1'b0;
    end else begin
      req_d  <= irq_req;
      cur_d  <= cur_secure;
      mask_d <= ns_mask_q;
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |-> !sel_valid);

  p_ns_target_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_secure && reg_addr == A_TARGET) |=> $stable(target_q));

  p_winner_requested_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> req_d[sel_id]);

  p_mask_blocks_ns_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && sel_nonsec) |-> !mask_d);

  p_idle_without_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_d == '0) |-> !sel_valid);

  p_cross_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (sel_cross == (sel_nonsec == cur_d)));

  p_flags_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (!sel_nonsec && !sel_cross));
endmodule

bind irq_sec_route isr_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cur_secure(cur_secure),
  .reg_wr(reg_wr), .reg_secure(reg_secure), .reg_addr(reg_addr),
  .sel_valid(sel_valid), .sel_id(sel_id), .sel_nonsec(sel_nonsec),
  .sel_cross(sel_cross), .target_q(target_q), .ns_mask_q(ns_mask_q)
);

// File: tb/sim_irq_sec_route.sv
`timescale 1ns/1ps
module sim_irq_sec_route;
  localparam int N = 6;
  localparam int IDW = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   irq_req = '0;
  logic [3*N-1:0] irq_prio = '1;
  logic           cur_secure = 1'b1;
  logic           reg_wr = 1'b0;
  logic           reg_secure = 1'b1;
  logic [1:0]     reg_addr = '0;
  logic [N-1:0]   reg_wdata = '0;
  logic [N-1:0]   reg_rdata;
  logic           sel_valid;
  logic [IDW-1:0] sel_id;
  logic           sel_nonsec;
  logic           sel_cross;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_sec_route #(.N(N)) u0 (.*);

  typedef struct packed {
    logic [5:0]  tgt;
    logic        dep;
    logic        msk;
    logic        cur;
    logic [5:0]  req;
    logic [17:0] pri;  // {p5,p4,p3,p2,p1,p0}
    logic        ev;
    logic [2:0]  eid;
    logic        ens;
    logic        ecr;
  } vec_t;

  localparam vec_t VECS [9] = '{
    // R8: nothing requested
    '{6'b000000, 1'b0, 1'b0, 1'b1, 6'b000000, {6{3'd0}}, 1'b0, 3'd0, 1'b0, 1'b0},
    // R5: lines 3 and 5 tie at 2, line 3 wins
    '{6'b000000, 1'b0, 1'b0, 1'b1, 6'b101100, {3'd2,3'd7,3'd2,3'd5,3'd7,3'd7}, 1'b1, 3'd3, 1'b0, 1'b0},
    // R4 R9 R10: non-secure line 2 wins while secure code runs
    '{6'b000100, 1'b0, 1'b0, 1'b1, 6'b000110, {3'd7,3'd7,3'd7,3'd3,3'd4,3'd7}, 1'b1, 3'd2, 1'b1, 1'b1},
    // R6: line 2 remapped 3 -> 5, secure line 1 at 4 wins
    '{6'b000100, 1'b1, 1'b0, 1'b1, 6'b000110, {3'd7,3'd7,3'd7,3'd3,3'd4,3'd7}, 1'b1, 3'd1, 1'b0, 1'b0},
    // R6 R5: line 0 remapped 0 -> 4 ties line 1, lower wins; non-secure running
    '{6'b000001, 1'b1, 1'b0, 1'b0, 6'b000011, {3'd7,3'd7,3'd7,3'd7,3'd4,3'd0}, 1'b1, 3'd0, 1'b1, 1'b0},
    // R7 R4: mask blocks line 0, secure line 1 wins from non-secure code
    '{6'b000001, 1'b0, 1'b1, 1'b0, 6'b000011, {3'd7,3'd7,3'd7,3'd7,3'd6,3'd0}, 1'b1, 3'd1, 1'b0, 1'b1},
    // R7: all lines non-secure and masked
    '{6'b111111, 1'b0, 1'b1, 1'b1, 6'b111111, {6{3'd0}}, 1'b0, 3'd0, 1'b0, 1'b0},
    // R5 R9: lines 0 and 5 tie at 7, line 0 wins, secure from non-secure code
    '{6'b100000, 1'b0, 1'b0, 1'b0, 6'b100001, {6{3'd7}}, 1'b1, 3'd0, 1'b0, 1'b1},
    // R6: line 5 (0 -> 4) beats line 4 (7 -> 7)
    '{6'b111111, 1'b1, 1'b0, 1'b1, 6'b110000, {3'd0,3'd7,3'd7,3'd7,3'd7,3'd7}, 1'b1, 3'd5, 1'b1, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sec, input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_secure = sec; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_secure = 1'b1;
  endtask

  task automatic rd(input logic sec, input logic [1:0] a, output logic [N-1:0] d);
    @(negedge clk);
    reg_secure = sec; reg_addr = a;
    #1 d = reg_rdata;
    reg_secure = 1'b1;
  endtask

  initial begin
    logic [N-1:0] r;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sel_valid == 1'b0, "R1 sel_valid", sel_valid, 0);
    rst_n = 1'b1;
    rd(1'b1, 2'd0, r); check(r == 0, "R1 targets", r, 0);
    rd(1'b1, 2'd1, r); check(r == 0, "R1 deprio", r, 0);
    rd(1'b1, 2'd2, r); check(r == 0, "R1 mask", r, 0);

    foreach (VECS[k]) begin
      wr(1'b1, 2'd0, VECS[k].tgt);
      wr(1'b1, 2'd1, {5'd0, VECS[k].dep});
      wr(1'b1, 2'd2, {5'd0, VECS[k].msk});
      @(negedge clk);
      irq_req = VECS[k].req; irq_prio = VECS[k].pri; cur_secure = VECS[k].cur;
      @(negedge clk);
      check(sel_valid == VECS[k].ev, $sformatf("R8 valid v%0d", k), sel_valid, VECS[k].ev);
      if (VECS[k].ev) begin
        check(sel_id == VECS[k].eid, $sformatf("R5 id v%0d", k), sel_id, VECS[k].eid);
        check(sel_nonsec == VECS[k].ens, $sformatf("R10 domain v%0d", k), sel_nonsec, VECS[k].ens);
        check(sel_cross == VECS[k].ecr, $sformatf("R9 cross v%0d", k), sel_cross, VECS[k].ecr);
      end
      irq_req = '0;
    end

    // R8: the output holds until the next edge
    wr(1'b1, 2'd2, 6'd0);
    @(negedge clk);
    irq_req = 6'b000001; irq_prio = '0;
    #1 check(sel_valid == 1'b0, "R8 latency", sel_valid, 0);
    @(negedge clk);
    check(sel_valid == 1'b1, "R8 after edge", sel_valid, 1);
    irq_req = '0;

    // R2: secure target write and readback
    wr(1'b1, 2'd0, 6'b101010);
    rd(1'b1, 2'd0, r); check(r == 6'b101010, "R2 readback", r, 6'b101010);
    // R3: non-secure writes ignored, reads hidden
    wr(1'b0, 2'd0, 6'b000000);
    rd(1'b1, 2'd0, r); check(r == 6'b101010, "R3 target kept", r, 6'b101010);
    rd(1'b0, 2'd0, r); check(r == 0, "R3 target hidden", r, 0);
    wr(1'b1, 2'd1, 6'd0);
    wr(1'b0, 2'd1, 6'd1);
    rd(1'b1, 2'd1, r); check(r == 0, "R3 deprio kept", r, 0);
    wr(1'b1, 2'd1, 6'd1);
    rd(1'b0, 2'd1, r); check(r == 0, "R3 deprio hidden", r, 0);
    // R7: mask written and read by non-secure domain
    wr(1'b0, 2'd2, 6'd1);
    rd(1'b0, 2'd2, r); check(r == 1, "R7 mask ns", r, 1);

    // R1: reset in mid-run clears state
    @(negedge clk);
    irq_req = 6'b000001;
    @(negedge clk);
    rst_n = 1'b0;
    #1 check(sel_valid == 1'b0, "R1 reset out", sel_valid, 0);
    @(negedge clk);
    irq_req = '0;
    rst_n = 1'b1;
    rd(1'b1, 2'd0, r); check(r == 0, "R1 targets again", r, 0);
    rd(1'b1, 2'd2, r); check(r == 0, "R1 mask again", r, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule